// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes one interrupt message and works out which processor slots it reaches. The message holds a 32-bit destination, a bit that selects physical or logical addressing, a 2-bit shorthand, a lowest-priority flag, and the slot index of the sender. Each of up to 32 slots describes itself with a present bit, an 8-bit legacy ID, a 32-bit extended ID, a flag for extended addressing, an 8-bit logical ID, and a bit that selects the flat or the cluster logical model. The logical ID a slot uses in extended mode is not an input. The block derives it from the slot's extended ID.

Legacy and extended slots can sit side by side. Each slot is matched under its own rules, so one message can reach both kinds. Two different broadcast encodings are recognised. When the lowest-priority flag is set, the resolved set is narrowed to one target. The result is registered, and it appears one clock after the message is presented. Delivering the vector to the chosen targets is left to other logic.

Top module: `irq_dest_resolver`

## Requirements
- R1: `out_valid` rises in the cycle after a cycle with `in_valid` high. `out_mask`, `out_found` and `out_target` are loaded only when `in_valid` is high and hold otherwise. After reset, all outputs are zero.
- R2: Shorthand value 1 yields only bit `sender`, whether that slot is present or not.
- R3: Shorthand value 2 yields all slots. Shorthand value 3 yields all slots except `sender`. In both cases the present bits are ignored.
- R4: With shorthand 0, `logical`=0 and a destination of 0xFFFFFFFF, every slot is marked, present or not.
- R5: In physical mode (`logical`=0), a present extended slot matches when its full 32-bit extended ID equals the destination. A present legacy slot matches when its 8-bit legacy ID equals destination bits [7:0].
- R6: In physical mode, a destination of exactly 0x000000FF also marks every present legacy slot.
- R7: In logical mode (`logical`=1), a destination of 0xFFFFFFFF marks every present extended slot. Legacy slots are still matched by their own logical rules.
- R8: An extended slot's logical ID is {ext_id[19:4], 16'b1 << ext_id[3:0]}. In logical mode the slot matches when destination[31:16] equals bits [31:16] of that ID and destination[15:0] AND bits [15:0] is nonzero.
- R9: A present legacy slot with `slot_cluster`=0 (flat) matches in logical mode when destination[7:0] AND its logical ID is nonzero.
- R10: A present legacy slot with `slot_cluster`=1 matches in logical mode when destination[7:4] is 0xF or equals logical ID[7:4], and destination[3:0] AND logical ID[3:0] is nonzero.
- R11: With shorthand 0, except for the case in R4, a slot whose present bit is 0 is never marked.
- R12: `out_found` is 1 when the resolved set is non-empty. `out_target` is the lowest set index of the resolved set, or 0 when the set is empty. With `lowest_pri`=1, `out_mask` is one-hot at that index, or zero when the set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Message present this cycle |
| dest | input | 32 | Destination field |
| logical | input | 1 | 0 = physical, 1 = logical addressing |
| shorthand | input | 2 | 0 = use dest, 1 = sender only, 2 = all, 3 = all but sender |
| lowest_pri | input | 1 | Narrow the result to one target |
| sender | input | 5 | Slot index of the sender |
| slot_present | input | 32 | Per-slot present bit |
| slot_xmode | input | 32 | Per-slot extended addressing flag |
| slot_cluster | input | 32 | Per-slot legacy logical model, 1 = cluster |
| slot_legacy_id | input | 256 | Per-slot 8-bit legacy ID, slot i at [8i+7:8i] |
| slot_ext_id | input | 1024 | Per-slot 32-bit extended ID, slot i at [32i+31:32i] |
| slot_log_id | input | 256 | Per-slot 8-bit legacy logical ID |
| out_valid | output | 1 | Result registered from last cycle's message |
| out_mask | output | 32 | Target set, or the single chosen target |
| out_found | output | 1 | Resolved set is non-empty |
| out_target | output | 5 | Lowest index in the resolved set |

## Verification
Each slot's match logic drives one bit of the mask. A wrong comparison, nibble select or broadcast decode in a slot therefore shows up as a single bit that is wrong in `out_mask` on the very next cycle. The error stays visible until the next message. A fault in the lowest-index picker shows up in `out_target`, and for lowest-priority messages as a mask that is not one-hot or has its bit in the wrong place, again one cycle after the message. The bench sets up the slots as a mix of flat, cluster, extended and absent slots, so that a single message exercises several of the match rules together.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
   localparam int DEST_W = 32;
   localparam int LEG_W  = 8;
   localparam int NIB_W  = LEG_W / 2;
   localparam int HALF_W = DEST_W / 2;

   typedef enum logic [1:0] {
      SH_FIELD  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   // Cluster in the upper half, one-hot member bit in the lower half.
   function automatic logic [DEST_W-1:0] ext_logical_id(input logic [DEST_W-1:0] id);
      logic [HALF_W-1:0] member;
      member = HALF_W'(1) << id[3:0];
      return {id[19:4], member};
   endfunction
endpackage

// File: rtl/irq_slot_match.sv
module irq_slot_match
   import irq_dest_pkg::*;
(
   input  logic [DEST_W-1:0] dest,
   input  logic              logical,
   input  logic              present,
   input  logic              xmode,
   input  logic              cluster,
   input  logic [LEG_W-1:0]  leg_id,
   input  logic [DEST_W-1:0] ext_id,
   input  logic [LEG_W-1:0]  log_id,
   output logic              hit
);
   localparam logic [DEST_W-1:0] LEG_BCAST = DEST_W'({LEG_W{1'b1}});
   localparam logic [NIB_W-1:0]  ALL_CLUSTERS = {NIB_W{1'b1}};

   logic              all_ones;
   logic [DEST_W-1:0] elid;
   logic              phys_hit;
   logic              xlog_hit;
   logic              flat_hit;
   logic              clus_hit;

   always_comb begin
      all_ones = &dest;
      elid     = ext_logical_id(ext_id);
      if (xmode) begin
         phys_hit = (ext_id == dest);
      end else begin
         phys_hit = (leg_id == dest[LEG_W-1:0]) || (dest == LEG_BCAST);
      end
      xlog_hit = all_ones ||
                 ((dest[DEST_W-1:HALF_W] == elid[DEST_W-1:HALF_W]) &&
                  (|(dest[HALF_W-1:0] & elid[HALF_W-1:0])));
      flat_hit = |(dest[LEG_W-1:0] & log_id);
      clus_hit = ((dest[LEG_W-1:NIB_W] == ALL_CLUSTERS) ||
                  (dest[LEG_W-1:NIB_W] == log_id[LEG_W-1:NIB_W])) &&
                 (|(dest[NIB_W-1:0] & log_id[NIB_W-1:0]));
      if (!present) begin
         hit = 1'b0;
      end else if (!logical) begin
         hit = phys_hit;
      end else if (xmode) begin
         hit = xlog_hit;
      end else begin
         hit = cluster ? clus_hit : flat_hit;
      end
   end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int N_SLOTS = 32,
   localparam int SLOT_W = $clog2(N_SLOTS)
) (
   input  logic [N_SLOTS-1:0] mask,
   output logic [N_SLOTS-1:0] onehot,
   output logic [SLOT_W-1:0]  idx,
   output logic               found
);
   always_comb begin
      onehot = mask & (~mask + N_SLOTS'(1));
      found  = |mask;
      idx    = '0;
      for (int i = N_SLOTS - 1; i >= 0; i--) begin
         if (mask[i]) idx = SLOT_W'(i);
      end
   end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int N_SLOTS = 32,
   localparam int SLOT_W = $clog2(N_SLOTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [DEST_W-1:0]         dest,
   input  logic                      logical,
   input  logic [1:0]                shorthand,
   input  logic                      lowest_pri,
   input  logic [SLOT_W-1:0]         sender,
   input  logic [N_SLOTS-1:0]        slot_present,
   input  logic [N_SLOTS-1:0]        slot_xmode,
   input  logic [N_SLOTS-1:0]        slot_cluster,
   input  logic [N_SLOTS*LEG_W-1:0]  slot_legacy_id,
   input  logic [N_SLOTS*DEST_W-1:0] slot_ext_id,
   input  logic [N_SLOTS*LEG_W-1:0]  slot_log_id,
   output logic                      out_valid,
   output logic [N_SLOTS-1:0]        out_mask,
   output logic                      out_found,
   output logic [SLOT_W-1:0]         out_target
);
   localparam logic [N_SLOTS-1:0] ALL_SLOTS = {N_SLOTS{1'b1}};
   localparam logic [N_SLOTS-1:0] ONE_SLOT  = N_SLOTS'(1);

   if (N_SLOTS < 2 || N_SLOTS > 32) begin : g_bad_slots
      $error("irq_dest_resolver: N_SLOTS must be within 2..32");
   end

   shorthand_e         sh;
   logic [N_SLOTS-1:0] field_hits;
   logic [N_SLOTS-1:0] resolved;
   logic [N_SLOTS-1:0] pick_onehot;
   logic [SLOT_W-1:0]  pick_idx;
   logic               pick_found;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      irq_slot_match u_match (
         .dest    (dest),
         .logical (logical),
         .present (slot_present[g]),
         .xmode   (slot_xmode[g]),
         .cluster (slot_cluster[g]),
         .leg_id  (slot_legacy_id[g*LEG_W +: LEG_W]),
         .ext_id  (slot_ext_id[g*DEST_W +: DEST_W]),
         .log_id  (slot_log_id[g*LEG_W +: LEG_W]),
         .hit     (field_hits[g])
      );
   end

   always_comb begin
      sh = shorthand_e'(shorthand);
      unique case (sh)
         SH_SELF:   resolved = ONE_SLOT << sender;
         SH_ALL:    resolved = ALL_SLOTS;
         SH_OTHERS: resolved = ALL_SLOTS & ~(ONE_SLOT << sender);
         default:   resolved = (!logical && (&dest)) ? ALL_SLOTS : field_hits;
      endcase
   end

   irq_lowest_pick #(.N_SLOTS(N_SLOTS)) u_pick (
      .mask   (resolved),
      .onehot (pick_onehot),
      .idx    (pick_idx),
      .found  (pick_found)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_mask   <= '0;
         out_found  <= 1'b0;
         out_target <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mask   <= lowest_pri ? pick_onehot : resolved;
            out_found  <= pick_found;
            out_target <= pick_idx;
         end
      end
   end

   // R1: the output register follows the message by exactly one cycle
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_mask) && $stable(out_target)));
   // R2: the sender-only shorthand gives exactly the sender's bit
   a_r2_self_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && shorthand == 2'd1) |=> (out_mask == (ONE_SLOT << $past(sender))));
   // R3: all-but-sender clears only the sender's bit
   a_r3_others: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && shorthand == 2'd3 && !lowest_pri) |=>
         (out_mask == (ALL_SLOTS & ~(ONE_SLOT << $past(sender)))));
   // R4: the physical all-ones destination reaches every slot
   a_r4_phys_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && shorthand == 2'd0 && !logical && (&dest) && !lowest_pri) |=>
         (out_mask == ALL_SLOTS));
   // R11: destination matching never marks an absent slot
   a_r11_absent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && shorthand == 2'd0 && !(!logical && (&dest))) |=>
         ((out_mask & ~$past(slot_present)) == '0));
   // R12: a lowest-priority result is at most one target, placed at out_target
   a_r12_single: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lowest_pri) |=>
         ($onehot0(out_mask) && (out_found == (out_mask != '0))));
   a_r12_target_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lowest_pri) |=> (!out_found || out_mask[out_target]));
endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;
   localparam int N = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     dest = '0;
   logic            logical = 1'b0;
   logic [1:0]      shorthand = '0;
   logic            lowest_pri = 1'b0;
   logic [4:0]      sender = '0;
   logic [N-1:0]    slot_present, slot_xmode, slot_cluster;
   logic [N*8-1:0]  slot_legacy_id, slot_log_id;
   logic [N*32-1:0] slot_ext_id;
   logic            out_valid, out_found;
   logic [N-1:0]    out_mask;
   logic [4:0]      out_target;

   logic        pres [N];
   logic        xm   [N];
   logic        clu  [N];
   logic [7:0]  lid  [N];
   logic [31:0] eid  [N];
   logic [7:0]  gid  [N];

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;
   string cur_tag = "R1";
   string exp_tag = "R1";

   logic         exp_valid = 0, exp_found = 0;
   logic [N-1:0] exp_mask = '0;
   logic [4:0]   exp_target = '0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         slot_present[i] = pres[i];
         slot_xmode[i]   = xm[i];
         slot_cluster[i] = clu[i];
         slot_legacy_id[i*8 +: 8] = lid[i];
         slot_log_id[i*8 +: 8]    = gid[i];
         slot_ext_id[i*32 +: 32]  = eid[i];
      end
   end

   irq_dest_resolver #(.N_SLOTS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest(dest),
      .logical(logical), .shorthand(shorthand), .lowest_pri(lowest_pri),
      .sender(sender), .slot_present(slot_present), .slot_xmode(slot_xmode),
      .slot_cluster(slot_cluster), .slot_legacy_id(slot_legacy_id),
      .slot_ext_id(slot_ext_id), .slot_log_id(slot_log_id),
      .out_valid(out_valid), .out_mask(out_mask), .out_found(out_found),
      .out_target(out_target)
   );

   // Behavioural reference: the target set as the requirements define it.
   function automatic logic [N-1:0] ref_set();
      logic [N-1:0] m;
      logic [31:0]  el;
      m = '0;
      if (shorthand == 2'd1) begin
         m[sender] = 1'b1;
      end else if (shorthand == 2'd2) begin
         m = '1;
      end else if (shorthand == 2'd3) begin
         m = '1;
         m[sender] = 1'b0;
      end else if (!logical && dest == 32'hFFFF_FFFF) begin
         m = '1;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (pres[i]) begin
               if (!logical) begin
                  if (xm[i]) m[i] = (eid[i] == dest);
                  else m[i] = (lid[i] == dest[7:0]) || (dest == 32'h0000_00FF);
               end else if (xm[i]) begin
                  el = (32'(eid[i][19:4]) << 16) | (32'd1 << eid[i][3:0]);
                  m[i] = (dest == 32'hFFFF_FFFF) ||
                         ((dest[31:16] == el[31:16]) && ((dest[15:0] & el[15:0]) != 0));
               end else if (clu[i]) begin
                  m[i] = ((dest[7:4] == 4'hF) || (dest[7:4] == gid[i][7:4])) &&
                         ((dest[3:0] & gid[i][3:0]) != 0);
               end else begin
                  m[i] = ((dest[7:0] & gid[i]) != 0);
               end
            end
         end
      end
      return m;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      logic [N-1:0] m;
      int lo;
      if (!rst_n) begin
         exp_valid <= 0; exp_mask <= '0; exp_found <= 0; exp_target <= '0;
      end else begin
         exp_valid <= in_valid;
         exp_tag   <= cur_tag;
         if (in_valid) begin
            m  = ref_set();
            lo = -1;
            for (int i = N - 1; i >= 0; i--) if (m[i]) lo = i;
            exp_found  <= (lo >= 0);
            exp_target <= (lo >= 0) ? 5'(lo) : 5'd0;
            if (lowest_pri) exp_mask <= (lo >= 0) ? (N'(1) << lo) : '0;
            else exp_mask <= m;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: out_valid actual %b expected %b", exp_tag, out_valid, exp_valid);
         end
         checks++;
         if (out_mask !== exp_mask) begin
            errors++;
            $display("FAIL %s: out_mask actual %h expected %h", exp_tag, out_mask, exp_mask);
         end
         checks++;
         if (out_found !== exp_found || out_target !== exp_target) begin
            errors++;
            $display("FAIL %s: found/target actual %b/%0d expected %b/%0d",
                     exp_tag, out_found, out_target, exp_found, exp_target);
         end
      end
   end

   task automatic send(input string tag, input logic [31:0] d, input logic lg,
                       input logic [1:0] sh, input logic lp, input logic [4:0] s);
      @(negedge clk);
      cur_tag = tag; dest = d; logical = lg; shorthand = sh; lowest_pri = lp;
      sender = s; in_valid = 1'b1;
   endtask

   task automatic idle(input string tag, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cur_tag = tag; in_valid = 1'b0; dest = $urandom; shorthand = 2'(k);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: cycles actual %0d expected below 100000", cycles);
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         pres[i] = 1; xm[i] = 0; clu[i] = 0; eid[i] = 32'hDEAD_0000 + i;
         if (i < 8) begin
            lid[i] = 8'h10 + 8'(i); gid[i] = 8'(1 << i);
         end else if (i < 14) begin
            clu[i] = 1; lid[i] = 8'h20 + 8'(i);
            gid[i] = {(i < 12) ? 4'h2 : 4'h3, 4'(1 << (i % 4))};
         end else if (i < 16) begin
            pres[i] = 0; lid[i] = 8'h40 + 8'(i); gid[i] = 8'hFF;
         end else if (i < 28) begin
            xm[i] = 1; lid[i] = 8'h10; gid[i] = 8'hFF;
            eid[i] = (i < 24) ? 32'h0000_0100 + 32'(i - 16) : 32'h0000_0200 + 32'(i - 24);
         end else begin
            pres[i] = 0; xm[i] = (i > 29); lid[i] = 8'h60 + 8'(i); gid[i] = 8'hFF;
            eid[i] = 32'h0000_0100 + 32'(i);
         end
      end
      repeat (3) @(negedge clk);   // R1 reset state is checked on every negedge here
      rst_n = 1'b1;
      send("R2", 32'h0, 0, 2'd1, 0, 5'd3);
      send("R2", 32'h0, 0, 2'd1, 0, 5'd15);      // absent sender still marked
      send("R3", 32'h0, 1, 2'd2, 0, 5'd7);
      send("R3", 32'h0, 0, 2'd3, 0, 5'd20);
      send("R4", 32'hFFFF_FFFF, 0, 2'd0, 0, 5'd0);
      send("R5", 32'h0000_0512, 0, 2'd0, 0, 5'd0); // legacy low byte only
      send("R5", 32'h0000_0101, 0, 2'd0, 0, 5'd0); // extended full ID
      send("R5", 32'h0000_0010, 0, 2'd0, 0, 5'd0); // extended ignores legacy ID
      send("R6", 32'h0000_00FF, 0, 2'd0, 0, 5'd0);
      send("R7", 32'hFFFF_FFFF, 1, 2'd0, 0, 5'd0);
      send("R8", 32'h0010_0005, 1, 2'd0, 0, 5'd0);
      send("R8", 32'h0020_0008, 1, 2'd0, 0, 5'd0);
      send("R8", 32'h0011_0005, 1, 2'd0, 0, 5'd0);
      send("R9", 32'h0000_0081, 1, 2'd0, 0, 5'd0);
      send("R10", 32'h0000_0023, 1, 2'd0, 0, 5'd0);
      send("R10", 32'h0000_00F8, 1, 2'd0, 0, 5'd0);
      send("R10", 32'h0000_0030, 1, 2'd0, 0, 5'd0);
      send("R11", 32'h0000_004E, 0, 2'd0, 0, 5'd0);
      send("R11", 32'h0000_007F, 0, 2'd0, 0, 5'd0);
      send("R12", 32'h0, 0, 2'd2, 1, 5'd9);
      send("R12", 32'h0, 0, 2'd3, 1, 5'd0);
      send("R12", 32'h0020_0003, 1, 2'd0, 1, 5'd0);
      send("R12", 32'h0000_0777, 0, 2'd0, 1, 5'd0);
      idle("R1", 4);
      send("R1", 32'h0000_0013, 0, 2'd0, 0, 5'd0);
      idle("R1", 3);
      for (int k = 0; k < 400; k++) begin
         logic [31:0] d;
         int pick;
         pick = $urandom_range(N - 1);
         case ($urandom_range(5))
            0: d = 32'hFFFF_FFFF;
            1: d = 32'h0000_00FF;
            2: d = $urandom;
            3: d = {16'(($urandom_range(2)) << 4), 16'($urandom)};
            4: d = 32'(lid[pick]) | ($urandom & 32'hFFFF_FF00);
            default: d = eid[pick];
         endcase
         send("R5", d, 1'($urandom), 2'($urandom_range(3) == 0 ? $urandom : 0),
              1'($urandom), 5'($urandom));
         if ($urandom_range(7) == 0) idle("R1", 1);
      end
      idle("R1", 2);
      finish_run();
   end
endmodule